// File: doc/BRIEF.md
# Memory Sleep Entry and Exit Controller

This block sits beside the cycle controller of a synchronous SRAM and governs a low-power sleep state. A sleep request arrives on an asynchronous, active-high pin. A low or undriven pin, which the pad pulls down, means normal operation. The block brings the request into the clock domain through a flop chain. It then walks a four-state machine that holds the memory in a fixed entry latency, a sleep state and a fixed recovery window. While the memory is not fully awake, it blocks every new access and forces the data bus to high impedance. Stored contents are retained across sleep. An access still pending when entry begins is treated as invalid and is not guaranteed to finish.

The states are AWAKE, ENTERING, ASLEEP and RECOVERING. The transitions are:
- AWAKE to ENTERING when the synchronised request is seen.
- ENTERING to ASLEEP when the entry count runs out.
- ENTERING to RECOVERING when the request drops before entry completes.
- ASLEEP to RECOVERING when the request drops.
- RECOVERING to AWAKE when the recovery count runs out. A request that returns during recovery is acted on only after this.

A one-cycle protocol-error pulse reports either of two misuses. The first is a request seen while the cycle controller does not report the device as deselected. The second is a chip enable or address strobe active during RECOVERING.

Top module: `nap_ctrl`

## Requirements
- R1: During and right after reset, the state is AWAKE and `sleep_active`, `block_access`, `bus_hiz` and `proto_err` are all 0.
- R2: `sleep_req_async` passes through SYNC_STAGES (default 2) flops. A level applied before clock edge k reaches the state logic after edge k+1, and no output reacts to it earlier.
- R3: When the synchronised request is seen in AWAKE, the state is ENTERING for exactly ENTRY_CYCLES (default 2) cycles. `sleep_active` then rises when ASLEEP is reached.
- R4: When the synchronised request is seen low in ASLEEP, the state is RECOVERING for exactly EXIT_CYCLES (default 2) cycles and then returns to AWAKE. `sleep_active` is 0 from the first RECOVERING cycle on.
- R5: `block_access` is 1 whenever the state is not AWAKE, and also in AWAKE while the synchronised request is 1.
- R6: `bus_hiz` is 1 in ENTERING, ASLEEP and RECOVERING, and 0 in AWAKE.
- R7: A synchronised request seen in AWAKE while `dev_idle` is 0 raises `proto_err` for the following cycle. Entry still proceeds.
- R8: Each cycle in RECOVERING with `access_req` at 1 raises `proto_err` for the following cycle only.
- R9: `access_req` in ENTERING or ASLEEP raises no error and leaves the state unchanged.
- R10: A request that drops while in ENTERING sends the state to RECOVERING, never to ASLEEP, for a full recovery window.
- R11: A request that returns during RECOVERING does not shorten the window. The state spends one cycle in AWAKE, with `bus_hiz` 0 and `block_access` 1, and then moves to ENTERING.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep_req_async | input | 1 | Raw sleep request, asynchronous, active high |
| dev_idle | input | 1 | 1 when the cycle controller has the device deselected |
| access_req | input | 1 | 1 when any chip enable or address strobe is active this cycle |
| sleep_active | output | 1 | 1 while in ASLEEP |
| block_access | output | 1 | Forces the cycle controller to deselect |
| bus_hiz | output | 1 | Forces the data bus drivers off |
| proto_err | output | 1 | One-cycle protocol violation pulse |

## Verification
A raw request edge reaches `block_access` two clock edges later. The state moves to ENTERING on the third edge, and `sleep_active` follows ENTRY_CYCLES edges after that. The exit path is the same: two synchroniser edges, then the EXIT_CYCLES recovery window, then AWAKE. An error condition shows on `proto_err` one edge after the cycle in which it held. The bench changes inputs only at falling edges and steps a behavioural model on each rising edge. It compares all four outputs at the next falling edge, so each result is read in the cycle it is due. The directed phases also check the stated cycle counts explicitly.

// File: rtl/nap_pkg.sv
package nap_pkg;
    typedef enum logic [1:0] {
        ST_AWAKE      = 2'd0,
        ST_ENTERING   = 2'd1,
        ST_ASLEEP     = 2'd2,
        ST_RECOVERING = 2'd3
    } nap_state_e;
endpackage

// File: rtl/nap_sync.sv
module nap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= d_async;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= 1'b0;
            else        chain[i] <= chain[i-1];
        end
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/nap_timer.sv
module nap_timer #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt <= '0;
        else if (load)           cnt <= load_val;
        else if (cnt != '0)      cnt <= cnt - W'(1);
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/nap_ctrl.sv
module nap_ctrl
    import nap_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int ENTRY_CYCLES = 2,
    parameter int EXIT_CYCLES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_req_async,
    input  logic dev_idle,
    input  logic access_req,
    output logic sleep_active,
    output logic block_access,
    output logic bus_hiz,
    output logic proto_err
);
    localparam int LONGEST = (ENTRY_CYCLES > EXIT_CYCLES) ? ENTRY_CYCLES : EXIT_CYCLES;
    localparam int CNT_W   = (LONGEST > 2) ? $clog2(LONGEST) : 1;
    localparam logic [CNT_W-1:0] ENTRY_LOAD = CNT_W'(ENTRY_CYCLES - 1);
    localparam logic [CNT_W-1:0] EXIT_LOAD  = CNT_W'(EXIT_CYCLES - 1);

    nap_state_e       state_q, state_nx;
    logic             req_s;
    logic             tmr_load, tmr_done;
    logic [CNT_W-1:0] tmr_val;
    logic             err_cond, err_q;

    nap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (sleep_req_async),
        .q_sync  (req_s)
    );

    // Next state
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_AWAKE:      if (req_s) state_nx = ST_ENTERING;
            ST_ENTERING: begin
                if (!req_s)        state_nx = ST_RECOVERING;
                else if (tmr_done) state_nx = ST_ASLEEP;
            end
            ST_ASLEEP:     if (!req_s) state_nx = ST_RECOVERING;
            ST_RECOVERING: if (tmr_done) state_nx = ST_AWAKE;
            default:       state_nx = ST_AWAKE;
        endcase
    end

    assign tmr_load = (state_nx != state_q);
    assign tmr_val  = (state_nx == ST_ENTERING) ? ENTRY_LOAD : EXIT_LOAD;

    nap_timer #(.W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_AWAKE;
        else        state_q <= state_nx;
    end

    // Outputs
    always_comb begin
        sleep_active = 1'b0;
        bus_hiz      = 1'b1;
        unique case (state_q)
            ST_AWAKE:      bus_hiz      = 1'b0;
            ST_ENTERING:   bus_hiz      = 1'b1;
            ST_ASLEEP:     sleep_active = 1'b1;
            ST_RECOVERING: bus_hiz      = 1'b1;
            default:       bus_hiz      = 1'b1;
        endcase
        block_access = bus_hiz | req_s;
    end

    // Protocol error pulse
    assign err_cond = ((state_q == ST_AWAKE) && req_s && !dev_idle) ||
                      ((state_q == ST_RECOVERING) && access_req);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= err_cond;
    end

    assign proto_err = err_q;

    // Checks
    a_r2_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(block_access) |-> $past(sleep_req_async, SYNC_STAGES));

    if (ENTRY_CYCLES >= 2) begin : g_chk_entry
        a_r3_entry_latency: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(sleep_active) |-> ($past(state_q) == ST_ENTERING) &&
                                    ($past(state_q, 2) == ST_ENTERING));
    end

    if (EXIT_CYCLES >= 2) begin : g_chk_exit
        a_r4_recovery_window: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(bus_hiz) |-> ($past(state_q) == ST_RECOVERING) &&
                               ($past(state_q, 2) == ST_RECOVERING));
    end

    a_r7_err_from_awake: assert property (@(posedge clk) disable iff (!rst_n)
        (proto_err && ($past(state_q) == ST_AWAKE)) |-> !$past(dev_idle));

    a_r8_err_from_recovery: assert property (@(posedge clk) disable iff (!rst_n)
        (proto_err && ($past(state_q) == ST_RECOVERING)) |-> $past(access_req));

    a_r9_quiet_when_asleep: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(state_q) == ST_ASLEEP) || ($past(state_q) == ST_ENTERING)) |-> !proto_err);
endmodule

// File: tb/sim_nap_ctrl.sv
module sim_nap_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int ENTRY = 2;
    localparam int EXIT  = 2;

    logic clk = 1'b0;
    logic rst_n, raw, idle, acc;
    logic sleep_o, block_o, hiz_o, err_o;
    int   n_chk = 0, n_fail = 0;

    // behavioural reference
    int   m_st = 0, m_left = 0;
    logic m_s1 = 0, m_s2 = 0, m_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nap_ctrl #(.SYNC_STAGES(2), .ENTRY_CYCLES(ENTRY), .EXIT_CYCLES(EXIT)) u0 (
        .clk(clk), .rst_n(rst_n), .sleep_req_async(raw), .dev_idle(idle),
        .access_req(acc), .sleep_active(sleep_o), .block_access(block_o),
        .bus_hiz(hiz_o), .proto_err(err_o)
    );

    task automatic chk(input logic act, input logic exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    // Model: 0 awake, 1 entering, 2 asleep, 3 recovering
    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_left = 0; m_s1 = 0; m_s2 = 0; m_err = 0;
        end else begin
            m_err = (m_st == 0 && m_s2 && !idle) || (m_st == 3 && acc);
            case (m_st)
                0: if (m_s2) begin m_st = 1; m_left = ENTRY; end
                1: if (!m_s2) begin m_st = 3; m_left = EXIT; end
                   else begin m_left--; if (m_left == 0) m_st = 2; end
                2: if (!m_s2) begin m_st = 3; m_left = EXIT; end
                default: begin m_left--; if (m_left == 0) m_st = 0; end
            endcase
            m_s2 = m_s1;
            m_s1 = raw;
        end
    end

    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            chk(sleep_o, m_st == 2,             "R3/R4 model sleep_active");
            chk(block_o, (m_st != 0) || m_s2,   "R5 model block_access");
            chk(hiz_o,   m_st != 0,             "R6 model bus_hiz");
            chk(err_o,   m_err,                 "R7/R8 model proto_err");
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0; raw = 1'b0; idle = 1'b1; acc = 1'b0;
        repeat (3) @(negedge clk);
        chk(sleep_o, 0, "R1 sleep in reset"); chk(block_o, 0, "R1 block in reset");
        chk(hiz_o, 0, "R1 hiz in reset");     chk(err_o, 0, "R1 err in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk(hiz_o, 0, "R1 hiz after reset");  chk(block_o, 0, "R1 block after reset");

        // entry
        raw = 1'b1;
        @(negedge clk); chk(block_o, 0, "R2 one edge");
        @(negedge clk); chk(block_o, 1, "R2 two edges"); chk(hiz_o, 0, "R5 block before hiz");
        @(negedge clk); chk(hiz_o, 1, "R6 entering hiz"); chk(sleep_o, 0, "R3 entering 1");
        @(negedge clk); chk(sleep_o, 0, "R3 entering 2");
        @(negedge clk); chk(sleep_o, 1, "R3 asleep");

        // strobes while asleep
        acc = 1'b1;
        @(negedge clk); @(negedge clk);
        chk(err_o, 0, "R9 no error asleep"); chk(sleep_o, 1, "R9 still asleep");
        acc = 1'b0;

        // exit with a strobe in recovery
        raw = 1'b0;
        @(negedge clk); @(negedge clk); chk(sleep_o, 1, "R4 asleep until sync");
        @(negedge clk); chk(sleep_o, 0, "R4 recovering"); chk(hiz_o, 1, "R4 recovering hiz");
        acc = 1'b1;
        @(negedge clk); chk(err_o, 1, "R8 strobe in recovery"); chk(hiz_o, 1, "R4 recovery 2");
        acc = 1'b0;
        @(negedge clk); chk(hiz_o, 0, "R4 awake"); chk(block_o, 0, "R5 awake open");
        chk(err_o, 0, "R8 single pulse");

        // request while not deselected
        idle = 1'b0; raw = 1'b1;
        @(negedge clk); @(negedge clk);
        @(negedge clk); chk(err_o, 1, "R7 busy request");
        idle = 1'b1;
        @(negedge clk); chk(err_o, 0, "R7 pulse ends");
        @(negedge clk); chk(sleep_o, 1, "R7 entry proceeds");

        // request returns during recovery
        raw = 1'b0;
        @(negedge clk); @(negedge clk);
        raw = 1'b1;
        @(negedge clk); chk(hiz_o, 1, "R11 recovering");
        @(negedge clk);
        @(negedge clk); chk(hiz_o, 0, "R11 awake gap"); chk(block_o, 1, "R11 blocked in gap");
        @(negedge clk); chk(hiz_o, 1, "R11 re-entering");
        @(negedge clk); @(negedge clk); chk(sleep_o, 1, "R11 asleep again");
        raw = 1'b0;
        repeat (6) @(negedge clk);
        chk(hiz_o, 0, "R4 awake again");

        // short pulse: abort during entry
        raw = 1'b1;
        @(negedge clk); raw = 1'b0;
        @(negedge clk);
        @(negedge clk); chk(hiz_o, 1, "R10 entering");
        @(negedge clk); chk(sleep_o, 0, "R10 no sleep"); chk(hiz_o, 1, "R10 recovering");
        @(negedge clk); chk(sleep_o, 0, "R10 recovering 2");
        @(negedge clk); chk(hiz_o, 0, "R10 back awake");

        // mixed stimulus against the model
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if ($urandom_range(0, 9) == 0) raw = ~raw;
            idle = ($urandom_range(0, 7) != 0);
            acc  = ($urandom_range(0, 3) == 0);
        end
        @(negedge clk);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule